// File: doc/BRIEF.md
# Almost-Flag Offset Unit

This block drives the almost-empty, almost-full and half-full status outputs of a FIFO. It takes the word count from the FIFO core and compares it against two programmable thresholds. The low threshold sets the almost-empty point and the high threshold sets the almost-full point. The FIFO storage and the plain empty/full logic are outside this block.

A master reset does two things. It loads default thresholds, and it fixes how they may be reprogrammed afterwards. The level of the load pin during master reset makes the choice. Low selects small defaults and parallel programming from the data bus. High selects large defaults and serial programming, one bit per clock, through the pin that is shared with the FIFO's mode select. A partial reset keeps the thresholds and the chosen method. It only restarts the programming and readback sequences and clears the status outputs to their idle levels.

The thresholds can always be read back in parallel on the output bus. All inputs are plain control and status pins on one write-side clock. There is no valid/ready stream and no back-pressure: each strobe that is low at a clock edge is acted on at that edge, and nothing can stall it.

Top module: `aflag_unit`

## Requirements
- R1: A clock edge with `mrst_n` low and `ld_n` low sets both thresholds to PAR_DEFAULT (127) and selects the parallel method until the next master reset.
- R2: A clock edge with `mrst_n` low and `ld_n` high sets both thresholds to SER_DEFAULT (1023) and selects the serial method until the next master reset.
- R3: The edge after a clock edge with `mrst_n` or `prst_n` low shows `pae_n`=0, `paf_n`=1, `hf_n`=1 and `q`=0.
- R4: A partial reset leaves both thresholds and the selected method unchanged. It returns the parallel-write, serial-bit and readback sequences to their first step, which is the almost-empty threshold.
- R5: With the parallel method selected, each edge with `ld_n`=0 and `wen_n`=0 writes `din[OFS_W-1:0]`. Writes alternate between the almost-empty threshold (first) and the almost-full threshold. With `ld_n`=1, `wen_n` has no effect on the thresholds.
- R6: With the serial method selected, each edge with `ld_n`=0 and `sen_n`=0 stores `mode_si` into one threshold bit. The order is the almost-empty bits 0 to OFS_W-1, then the almost-full bits 0 to OFS_W-1, and then the sequence wraps back to the start.
- R7: A parallel write attempted under the serial method, or a serial write attempted under the parallel method, leaves both thresholds unchanged.
- R8: Under either method, each edge with `ld_n`=0 and `ren_n`=0 puts a threshold on `q` one cycle later, zero-extended. Reads alternate between almost-empty (first) and almost-full. The value read is the one held before that edge. Otherwise `q` holds its value.
- R9: One edge after `count` is sampled, `pae_n` is 0 exactly when `count` is less than or equal to the almost-empty threshold.
- R10: One edge after `count` is sampled, `paf_n` is 0 exactly when `DEPTH - count` is less than or equal to the almost-full threshold.
- R11: One edge after `count` is sampled, `hf_n` is 0 exactly when `count` is greater than DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled at the clock edge |
| prst_n | input | 1 | Partial reset, active low, sampled at the clock edge |
| ld_n | input | 1 | Load pin: chooses the method during master reset; enables programming and readback afterwards |
| wen_n | input | 1 | Parallel write strobe, active low |
| ren_n | input | 1 | Readback strobe, active low |
| sen_n | input | 1 | Serial bit strobe, active low |
| mode_si | input | 1 | Shared mode-select / serial data pin |
| din | input | DATA_W | Data bus; the low OFS_W bits are used for parallel writes |
| count | input | CNT_W | Current word count from the FIFO core, 0 to DEPTH |
| q | output | DATA_W | Threshold readback bus |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
The assertions assume a few things about the inputs. `count` never exceeds DEPTH. A master reset is applied before anything else. The strobes are stable around the clock edge. The random stimulus draws `count` only from 0 to DEPTH, and it biases the draw toward the two thresholds, zero, full and the half point, where the flag comparisons change. Each run opens with a master reset. Strobes, load level, data and serial bits are then mixed with occasional partial and master resets of both load levels, so every method, wrong-method attempt and sequence restart comes up many times.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
  // Which threshold register a sequence step addresses.
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  function automatic ofs_sel_e sel_next(input ofs_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/aflag_offset_bank.sv
module aflag_offset_bank
  import aflag_pkg::*;
#(
  parameter int OFS_W       = 11,
  parameter int PAR_DEFAULT = 127,
  parameter int SER_DEFAULT = 1023
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ld_n,
  input  logic             wen_n,
  input  logic             sen_n,
  input  logic             si,
  input  logic [OFS_W-1:0] wdata,
  output logic [OFS_W-1:0] ofs_e,
  output logic [OFS_W-1:0] ofs_f,
  output logic             serial_mode
);
  localparam int BITS  = 2 * OFS_W;
  localparam int IDX_W = $clog2(BITS);
  localparam logic [OFS_W-1:0] DEF_P = OFS_W'(PAR_DEFAULT);
  localparam logic [OFS_W-1:0] DEF_S = OFS_W'(SER_DEFAULT);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(BITS - 1);

  ofs_sel_e         wsel;
  logic [IDX_W-1:0] bidx;
  logic             ser_wr, par_wr;
  logic [OFS_W-1:0] nxt_e, nxt_f;

  // Only the method chosen at master reset may write.
  assign ser_wr = serial_mode  && !ld_n && !sen_n;
  assign par_wr = !serial_mode && !ld_n && !wen_n;

  // Per-bit decode of the serial index; a parallel write replaces a whole word.
  always_comb begin
    nxt_e = ofs_e;
    nxt_f = ofs_f;
    for (int i = 0; i < OFS_W; i++) begin
      if (ser_wr && bidx == IDX_W'(i))         nxt_e[i] = si;
      if (ser_wr && bidx == IDX_W'(i + OFS_W)) nxt_f[i] = si;
    end
    if (par_wr) begin
      if (wsel == SEL_EMPTY) nxt_e = wdata;
      else                   nxt_f = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      serial_mode <= ld_n;
      ofs_e       <= ld_n ? DEF_S : DEF_P;
      ofs_f       <= ld_n ? DEF_S : DEF_P;
      wsel        <= SEL_EMPTY;
      bidx        <= '0;
    end else if (!prst_n) begin
      wsel        <= SEL_EMPTY;
      bidx        <= '0;
    end else begin
      ofs_e <= nxt_e;
      ofs_f <= nxt_f;
      if (par_wr) wsel <= sel_next(wsel);
      if (ser_wr) bidx <= (bidx == LAST) ? '0 : bidx + 1'b1;
    end
  end

  // R4: partial reset keeps thresholds and method
  a_r4_prst_keeps: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> $stable(serial_mode) && $stable(ofs_e) && $stable(ofs_f));

  // R7: serial method: no change without a serial strobe
  a_r7_serial_blocks_parallel: assert property (@(posedge clk) disable iff (!mrst_n)
    (serial_mode && (ld_n || sen_n)) |=> $stable(ofs_e) && $stable(ofs_f));

  // R7: parallel method: no change without a parallel strobe
  a_r7_parallel_blocks_serial: assert property (@(posedge clk) disable iff (!mrst_n)
    (!serial_mode && (ld_n || wen_n)) |=> $stable(ofs_e) && $stable(ofs_f));

  // R5: a parallel write lands in one of the two thresholds
  a_r5_par_lands: assert property (@(posedge clk) disable iff (!mrst_n)
    (!serial_mode && !ld_n && !wen_n && prst_n)
      |=> (ofs_e == $past(wdata)) || (ofs_f == $past(wdata)));

  // R6: the method never changes outside master reset
  a_r6_method_fixed: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(serial_mode));
endmodule

// File: rtl/aflag_readback.sv
module aflag_readback
  import aflag_pkg::*;
#(
  parameter int OFS_W  = 11,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld_n,
  input  logic              ren_n,
  input  logic [OFS_W-1:0]  ofs_e,
  input  logic [OFS_W-1:0]  ofs_f,
  output logic [DATA_W-1:0] q
);
  ofs_sel_e rsel;
  logic     rd;

  assign rd = !ld_n && !ren_n;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      rsel <= SEL_EMPTY;
      q    <= '0;
    end else if (rd) begin
      q    <= DATA_W'((rsel == SEL_EMPTY) ? ofs_e : ofs_f);
      rsel <= sel_next(rsel);
    end
  end

  // R8: readback returns a threshold held before the edge
  a_r8_q_source: assert property (@(posedge clk) disable iff (!mrst_n)
    (rd && prst_n) |=> (q == DATA_W'($past(ofs_e))) || (q == DATA_W'($past(ofs_f))));

  // R8: q holds without a read strobe
  a_r8_q_hold: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rd && prst_n) |=> $stable(q));

  // R3: partial reset clears the readback bus
  a_r3_q_clear: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (q == '0));
endmodule

// File: rtl/aflag_compare.sv
module aflag_compare #(
  parameter int DEPTH = 16384,
  parameter int OFS_W = 11,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [OFS_W-1:0] ofs_e,
  input  logic [OFS_W-1:0] ofs_f,
  output logic             pae_n,
  output logic             paf_n,
  output logic             hf_n
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] free_w;
  logic             near_empty, near_full, past_half;

  assign free_w     = FULL - count;
  assign near_empty = count  <= CNT_W'(ofs_e);
  assign near_full  = free_w <= CNT_W'(ofs_f);
  assign past_half  = count > HALF;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      pae_n <= 1'b0;
      paf_n <= 1'b1;
      hf_n  <= 1'b1;
    end else begin
      pae_n <= !near_empty;
      paf_n <= !near_full;
      hf_n  <= !past_half;
    end
  end

  // R9: an empty FIFO is always almost empty
  a_r9_zero_is_almost_empty: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && count == '0) |=> !pae_n && hf_n);

  // R10, R11: a full FIFO is almost full and past half
  a_r10_full_is_almost_full: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && count == FULL) |=> !paf_n && !hf_n);

  // R3: idle flag levels after partial reset
  a_r3_flags_idle: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> !pae_n && paf_n && hf_n);
endmodule

// File: rtl/aflag_unit.sv
module aflag_unit #(
  parameter int DEPTH       = 16384,
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 11,
  parameter int PAR_DEFAULT = 127,
  parameter int SER_DEFAULT = 1023,
  localparam int CNT_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic              sen_n,
  input  logic              mode_si,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] q,
  output logic              pae_n,
  output logic              paf_n,
  output logic              hf_n
);
  logic [OFS_W-1:0] ofs_e, ofs_f;
  logic             serial_mode;

  aflag_offset_bank #(
    .OFS_W(OFS_W), .PAR_DEFAULT(PAR_DEFAULT), .SER_DEFAULT(SER_DEFAULT)
  ) u_bank (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n),
    .wen_n(wen_n), .sen_n(sen_n), .si(mode_si), .wdata(din[OFS_W-1:0]),
    .ofs_e(ofs_e), .ofs_f(ofs_f), .serial_mode(serial_mode)
  );

  aflag_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .ren_n(ren_n),
    .ofs_e(ofs_e), .ofs_f(ofs_f), .q(q)
  );

  aflag_compare #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .count(count),
    .ofs_e(ofs_e), .ofs_f(ofs_f), .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  // R1, R2: master reset picks the defaults from the load level
  a_r1_r2_defaults: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (ofs_e == ofs_f) &&
      ((serial_mode && ofs_e == OFS_W'(SER_DEFAULT)) ||
       (!serial_mode && ofs_e == OFS_W'(PAR_DEFAULT))));
endmodule

// File: tb/tb_aflag_unit.sv
module tb_aflag_unit;
  localparam int DEPTH  = 16384;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 11;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, ld_n = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1, sen_n = 1'b1, mode_si = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [CNT_W-1:0]  count = '0;
  logic [DATA_W-1:0] q;
  logic pae_n, paf_n, hf_n;

  always #4 clk = ~clk;

  aflag_unit dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .wen_n(wen_n),
    .ren_n(ren_n), .sen_n(sen_n), .mode_si(mode_si), .din(din), .count(count),
    .q(q), .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
  );

  int vectors = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [OFS_W-1:0] m_e = '0, m_f = '0;
  bit m_ser = 0, m_wsel = 0, m_rsel = 0;
  int m_bidx = 0;
  logic e_pae = 0, e_paf = 1, e_hf = 1;
  logic [DATA_W-1:0] e_q = '0;

  function automatic logic f_pae(int c, int th); return !(c <= th); endfunction
  function automatic logic f_paf(int c, int th); return !((DEPTH - c) <= th); endfunction
  function automatic logic f_hf(int c); return !(c > DEPTH / 2); endfunction

  task automatic model_edge();
    int c = int'(count);
    if (!mrst_n) begin
      m_ser = ld_n; m_e = ld_n ? OFS_W'(1023) : OFS_W'(127); m_f = m_e;
      m_wsel = 0; m_rsel = 0; m_bidx = 0;
      e_pae = 0; e_paf = 1; e_hf = 1; e_q = '0;
    end else if (!prst_n) begin
      m_wsel = 0; m_rsel = 0; m_bidx = 0;
      e_pae = 0; e_paf = 1; e_hf = 1; e_q = '0;
    end else begin
      e_pae = f_pae(c, int'(m_e));
      e_paf = f_paf(c, int'(m_f));
      e_hf  = f_hf(c);
      if (!ld_n && !ren_n) begin
        e_q = DATA_W'(m_rsel ? m_f : m_e);
        m_rsel = !m_rsel;
      end
      if (m_ser && !ld_n && !sen_n) begin
        if (m_bidx < OFS_W) m_e[m_bidx] = mode_si;
        else m_f[m_bidx - OFS_W] = mode_si;
        m_bidx = (m_bidx == 2 * OFS_W - 1) ? 0 : m_bidx + 1;
      end
      if (!m_ser && !ld_n && !wen_n) begin
        if (!m_wsel) m_e = din[OFS_W-1:0]; else m_f = din[OFS_W-1:0];
        m_wsel = !m_wsel;
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock: inputs are already set; model at the edge, compare at the negedge.
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vectors++;
    chk(tag, 32'(pae_n), 32'(e_pae), "pae_n");
    chk(tag, 32'(paf_n), 32'(e_paf), "paf_n");
    chk(tag, 32'(hf_n),  32'(e_hf),  "hf_n");
    chk(tag, 32'(q),     32'(e_q),   "q");
  endtask

  task automatic idle();
    mrst_n = 1; prst_n = 1; ld_n = 1; wen_n = 1; ren_n = 1; sen_n = 1;
  endtask

  task automatic master(bit ld, string tag);
    idle(); mrst_n = 0; ld_n = ld; cyc(tag); idle();
  endtask

  task automatic par_write(int v, string tag);
    ld_n = 0; wen_n = 0; din = DATA_W'(v); cyc(tag); idle();
  endtask

  task automatic ser_write(int e, int f, string tag);
    for (int i = 0; i < 2 * OFS_W; i++) begin
      ld_n = 0; sen_n = 0;
      mode_si = (i < OFS_W) ? e[i] : f[i - OFS_W];
      cyc(tag);
    end
    idle();
  endtask

  task automatic read_both(int ee, int ef, string tag);
    ld_n = 0; ren_n = 0; cyc(tag);
    vectors++; chk(tag, 32'(q), 32'(ee), "readback empty threshold");
    cyc(tag);
    vectors++; chk(tag, 32'(q), 32'(ef), "readback full threshold");
    idle();
  endtask

  task automatic flag_at(int c, string tag);
    count = CNT_W'(c); cyc(tag);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    // R1, R3: master reset with load low
    mrst_n = 0; ld_n = 0; cyc("R3");
    vectors++; chk("R3", {pae_n, paf_n, hf_n}, 3'b011, "flags after master reset");
    chk("R3", 32'(q), 0, "q after master reset");
    idle();
    read_both(127, 127, "R1");
    // R5: parallel loads alternate
    par_write(5, "R5"); par_write(200, "R5");
    read_both(5, 200, "R5");
    // R7: serial attempt ignored under parallel method
    ser_write(1, 2, "R7");
    read_both(5, 200, "R7");
    // R5: wen with ld high ignored
    wen_n = 0; din = 18'h3; cyc("R5"); idle();
    read_both(5, 200, "R5");
    // R9, R10, R11: flag boundaries
    flag_at(5, "R9"); vectors++; chk("R9", 32'(pae_n), 0, "count equal threshold");
    flag_at(6, "R9"); vectors++; chk("R9", 32'(pae_n), 1, "count above threshold");
    flag_at(DEPTH - 200, "R10"); vectors++; chk("R10", 32'(paf_n), 0, "free equal threshold");
    flag_at(DEPTH - 201, "R10"); vectors++; chk("R10", 32'(paf_n), 1, "free above threshold");
    flag_at(DEPTH / 2, "R11"); vectors++; chk("R11", 32'(hf_n), 1, "count at half");
    flag_at(DEPTH / 2 + 1, "R11"); vectors++; chk("R11", 32'(hf_n), 0, "count past half");
    // R4: partial reset keeps values and restarts the sequence
    par_write(9, "R4");
    prst_n = 0; cyc("R4"); idle();
    vectors++; chk("R4", {pae_n, paf_n, hf_n}, 3'b011, "flags after partial reset");
    par_write(33, "R4");
    read_both(33, 200, "R4");
    // R2: master reset with load high
    count = '0;
    master(1'b1, "R2");
    read_both(1023, 1023, "R2");
    // R7: parallel attempt ignored under serial method
    par_write(4, "R7"); par_write(4, "R7");
    read_both(1023, 1023, "R7");
    // R6: serial load, LSB first, empty then full
    ser_write(11'h2A5, 11'h15A, "R6");
    read_both(11'h2A5, 11'h15A, "R6");
    flag_at(11'h2A5, "R6");
    // R8: readback overlapping a load returns old value
    ld_n = 0; ren_n = 0; sen_n = 0; mode_si = 0; cyc("R8"); idle();
    vectors++; chk("R8", 32'(q), 32'h2A5, "read during serial bit");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 1000;
      int k = $urandom % 6;
      int c;
      mrst_n = (r < 5) ? 1'b0 : 1'b1;
      prst_n = (r >= 5 && r < 25) ? 1'b0 : 1'b1;
      ld_n = $urandom % 2; wen_n = $urandom % 2; ren_n = $urandom % 2;
      sen_n = $urandom % 2; mode_si = $urandom % 2;
      din = DATA_W'($urandom);
      case (k)
        0: c = $urandom % 16;
        1: c = DEPTH - ($urandom % 16);
        2: c = DEPTH / 2 - 2 + ($urandom % 5);
        3: c = int'(m_e) - 1 + ($urandom % 3);
        4: c = DEPTH - int'(m_f) - 1 + ($urandom % 3);
        default: c = $urandom % (DEPTH + 1);
      endcase
      if (c < 0) c = 0;
      if (c > DEPTH) c = DEPTH;
      count = CNT_W'(c);
      cyc("R9");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule